// File: doc/BRIEF.md
# Byte-Wide Synchronous Configuration Loader

This block sits on the receiving side of a byte-wide synchronous configuration port. A host drives an 8-bit data bus and a slow configuration clock. The block oversamples that clock on a fast reference clock and takes one byte on a rising edge. It then hands the bits on, least significant first, as a serial stream with one strobe per falling edge of the configuration clock. Because each byte occupies eight falling edges, the next byte is taken on the ninth rising edge. Rising edges that arrive while a byte is still being spread out change nothing.

The active-low configuration reset restarts the whole load. When it rises, a hold-off measured in reference clocks begins, and configuration-clock edges are ignored until it ends. After a fixed number of bytes, the block raises a completion flag and stops taking data. The host must then supply a set number of further rising edges before the block signals that the device may enter user mode.

All edges seen at the configuration clock pin reach the outputs with a fixed latency of SYNC_STAGES+1 reference clocks. With the default settings this is three cycles.

Top module: `ppsl_loader`

## Requirements
- R1: While rst_ni is low, bit_vld_o, done_o and user_mode_o are 0 at once, without waiting for a clock edge, and the load starts again from its first byte.
- R2: Edges on dclk_i are ignored for the first HOLD_CYC reference clocks after rst_ni rises (default 500, which is 5 µs at 100 MHz).
- R3: On the first valid rising edge of dclk_i, data_i is captured. Each of the next 8 falling edges gives exactly one single-cycle pulse on bit_vld_o. Each output change appears SYNC_STAGES+1 reference clocks after the dclk_i edge that caused it.
- R4: The bits of each captured byte are emitted least significant bit first on bit_o.
- R5: Rising edges that arrive before the 8th bit of the current byte has been emitted are ignored. The next byte is captured on the ninth rising edge, counted from the previous capture.
- R6: done_o rises one reference clock after the strobe of bit TOTAL_BYTES*8 (default 4 bytes). It stays high until rst_ni goes low.
- R7: Once done_o is high, rising edges capture nothing and bit_vld_o stays 0.
- R8: user_mode_o rises on the INIT_CLKS-th rising edge of dclk_i after done_o (default 10). After the (INIT_CLKS-1)-th such edge it is still 0.
- R9: dclk_i high and low phases as short as 5 reference clocks (50 ns at 100 MHz) are handled without losing or duplicating an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock used for oversampling and the hold-off |
| rst_ni | input | 1 | Active-low asynchronous configuration reset |
| dclk_i | input | 1 | Host configuration clock, asynchronous to clk_i |
| data_i | input | DATA_W | Configuration byte bus |
| bit_o | output | 1 | Serialized configuration bit, valid while bit_vld_o is high |
| bit_vld_o | output | 1 | One-cycle strobe per emitted bit |
| done_o | output | 1 | All configuration bytes have been emitted |
| user_mode_o | output | 1 | Initialization clocks are complete |

## Verification
The bench keeps junk values on the bus during the seven rising edges that fall inside each byte. A design that reloads on any rising edge would emit those junk bits, and the reassembled stream would no longer match. It toggles the clock inside the hold-off window, where a missing or shortened hold-off shows up as early strobes. After the last byte it keeps supplying rising edges that carry data. The user-mode flag is checked to be 0 after nine of those edges and 1 after ten, so an off-by-one counter or a loader that keeps capturing is exposed. A second load after a mid-run reset uses minimum-width clock phases, to catch edges that are lost or counted twice in the synchronizer.

// File: rtl/ppsl_pkg.sv
package ppsl_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ppsl_edge_sync.sv
module ppsl_edge_sync
  import ppsl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dclk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              armed_i,
  output edge_t             edge_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] dsync_q;
  logic                   dprev_q;
  logic [DATA_W-1:0]      dpipe_q [SYNC_STAGES];

  // data follows the same depth as the clock so a capture sees the byte driven with the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsync_q <= '0;
      dprev_q <= 1'b0;
      for (int i = 0; i < int'(SYNC_STAGES); i++) dpipe_q[i] <= '0;
    end else begin
      for (int i = int'(SYNC_STAGES) - 1; i > 0; i--) begin
        dsync_q[i] <= dsync_q[i-1];
        dpipe_q[i] <= dpipe_q[i-1];
      end
      dsync_q[0] <= dclk_i;
      dpipe_q[0] <= data_i;
      dprev_q    <= dsync_q[LAST];
    end
  end

  assign edge_o.rise = armed_i &  dsync_q[LAST] & ~dprev_q;
  assign edge_o.fall = armed_i & ~dsync_q[LAST] &  dprev_q;
  assign data_o      = dpipe_q[LAST];
endmodule

// File: rtl/ppsl_holdoff.sv
module ppsl_holdoff #(
  parameter int unsigned HOLD_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == CW'(HOLD_CYC));

  p_armed_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);
endmodule

// File: rtl/ppsl_serializer.sv
module ppsl_serializer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              bit_vld_o
);
  localparam int unsigned PW = $clog2(DATA_W + 1);

  logic [PW-1:0]     ph_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      sh_q      <= '0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (fall_i && ph_q != '0) begin
        bit_vld_o <= 1'b1;
        bit_o     <= sh_q[0];
        sh_q      <= sh_q >> 1;
        ph_q      <= ph_q - 1'b1;
      end else if (rise_i && ph_q == '0 && accept_i) begin
        sh_q <= data_i;
        ph_q <= PW'(DATA_W);
      end
    end
  end

  p_ph_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PW'(DATA_W));

  p_busy_rise_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !fall_i && ph_q != '0) |=> (ph_q == $past(ph_q)));
endmodule

// File: rtl/ppsl_init_ctrl.sv
module ppsl_init_ctrl #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TOTAL_BYTES = 4,
  parameter int unsigned INIT_CLKS   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic rise_i,
  output logic accept_o,
  output logic done_o,
  output logic user_o
);
  localparam int unsigned TOTAL_BITS = TOTAL_BYTES * DATA_W;
  localparam int unsigned BW         = $clog2(TOTAL_BITS + 1);
  localparam int unsigned IW         = $clog2(INIT_CLKS + 1);

  logic [BW-1:0] bits_q;
  logic [IW-1:0] icnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      done_o <= 1'b0;
    end else if (bit_vld_i && !done_o) begin
      bits_q <= bits_q + 1'b1;
      if (bits_q == BW'(TOTAL_BITS - 1)) done_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      user_o <= 1'b0;
    end else if (rise_i && done_o && !user_o) begin
      icnt_q <= icnt_q + 1'b1;
      if (icnt_q == IW'(INIT_CLKS - 1)) user_o <= 1'b1;
    end
  end

  assign accept_o = ~done_o;

  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_no_strobe_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bit_vld_i);

  p_user_needs_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_o |-> done_o);
endmodule

// File: rtl/ppsl_loader.sv
module ppsl_loader
  import ppsl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TOTAL_BYTES = 4,
  parameter int unsigned INIT_CLKS   = 10,
  parameter int unsigned HOLD_CYC    = 500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dclk_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              done_o,
  output logic              user_mode_o
);
  logic              armed;
  logic              accept;
  edge_t             dedge;
  logic [DATA_W-1:0] dbus;

  ppsl_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_o (armed)
  );

  ppsl_edge_sync #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dclk_i  (dclk_i),
    .data_i  (data_i),
    .armed_i (armed),
    .edge_o  (dedge),
    .data_o  (dbus)
  );

  ppsl_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (dedge.rise),
    .fall_i    (dedge.fall),
    .accept_i  (accept),
    .data_i    (dbus),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
  );

  ppsl_init_ctrl #(
    .DATA_W      (DATA_W),
    .TOTAL_BYTES (TOTAL_BYTES),
    .INIT_CLKS   (INIT_CLKS)
  ) u_init (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_o),
    .rise_i    (dedge.rise),
    .accept_o  (accept),
    .done_o    (done_o),
    .user_o    (user_mode_o)
  );

  p_quiet_holdoff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> !bit_vld_o);
endmodule

// File: tb/ppsl_loader_tb.sv
module ppsl_loader_tb;
  localparam int HOLD = 500;
  localparam int TOT  = 4;
  localparam int INIT = 10;
  localparam int LAT  = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dclk_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       bit_o, bit_vld_o, done_o, user_mode_o;

  ppsl_loader u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .dclk_i (dclk_i), .data_i (data_i),
    .bit_o (bit_o), .bit_vld_o (bit_vld_o), .done_o (done_o), .user_mode_o (user_mode_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int m_ph, m_bits, m_icnt, done_at, user_at;
  logic [7:0] m_sh;
  logic prev_dclk;
  logic slot_v [8];
  logic slot_b [8];
  logic rx_bits [$];
  logic [7:0] tx_bytes [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    m_ph = 0; m_bits = 0; m_icnt = 0; done_at = -1; user_at = -1;
    m_sh = '0; prev_dclk = 1'b0;
    for (int i = 0; i < 8; i++) begin slot_v[i] = 1'b0; slot_b[i] = 1'b0; end
    rx_bits.delete();
    tx_bytes.delete();
  endtask

  task automatic model_edge(input logic dv, input logic [7:0] dd, input int c);
    bit valid, doneq;
    valid = (c + 2 >= HOLD);
    doneq = (done_at >= 0) && (done_at <= c + 2);
    if (valid && dv && !prev_dclk) begin
      if (doneq) begin
        if (m_icnt < INIT) begin
          m_icnt++;
          if (m_icnt == INIT) user_at = c + LAT;
        end
      end else if (m_ph == 0) begin
        m_sh = dd; m_ph = 8;
      end
    end else if (valid && !dv && prev_dclk && m_ph > 0) begin
      slot_v[(c + LAT) % 8] = 1'b1;
      slot_b[(c + LAT) % 8] = m_sh[0];
      m_sh = m_sh >> 1;
      m_ph--;
      m_bits++;
      if (m_bits == TOT * 8) done_at = c + LAT + 1;
    end
    prev_dclk = dv;
  endtask

  task automatic tick(input logic dv, input logic [7:0] dd);
    logic ev, eb, ed, eu;
    @(negedge clk_i);
    ev = slot_v[cyc % 8];
    eb = slot_b[cyc % 8];
    slot_v[cyc % 8] = 1'b0;
    ed = (done_at >= 0) && (cyc >= done_at);
    eu = (user_at >= 0) && (cyc >= user_at);
    chk(bit_vld_o == ev, "R3", "bit_vld_o", int'(bit_vld_o), int'(ev));
    if (ev && bit_vld_o) chk(bit_o == eb, "R4", "bit_o", int'(bit_o), int'(eb));
    chk(done_o == ed, "R6", "done_o", int'(done_o), int'(ed));
    chk(user_mode_o == eu, "R8", "user_mode_o", int'(user_mode_o), int'(eu));
    if (bit_vld_o) rx_bits.push_back(bit_o);
    dclk_i = dv;
    data_i = dd;
    model_edge(dv, dd, cyc);
    cyc++;
  endtask

  task automatic hold(input logic dv, input logic [7:0] dd, input int n);
    for (int i = 0; i < n; i++) tick(dv, dd);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    dclk_i = 1'b0;
    #1;
    chk(bit_vld_o == 1'b0, "R1", "bit_vld_o in reset", int'(bit_vld_o), 0);
    chk(done_o == 1'b0, "R1", "done_o in reset", int'(done_o), 0);
    chk(user_mode_o == 1'b0, "R1", "user_mode_o in reset", int'(user_mode_o), 0);
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc = 1;
  endtask

  // one byte: capture rise, then 8 falls with junk-carrying rises between them
  task automatic send_byte(input logic [7:0] b, input int ph);
    tx_bytes.push_back(b);
    hold(1'b1, b, ph);
    for (int i = 0; i < 8; i++) begin
      hold(1'b0, b, ph);
      if (i < 7) hold(1'b1, ~b ^ 8'(i), ph);
    end
  endtask

  task automatic post_done(input int ph);
    int nstrobe;
    nstrobe = rx_bits.size();
    chk(done_o == 1'b1, "R6", "done_o after last byte", int'(done_o), 1);
    for (int i = 0; i < INIT - 1; i++) begin
      hold(1'b1, 8'hC9, ph);
      hold(1'b0, 8'hC9, ph);
    end
    chk(user_mode_o == 1'b0, "R8", "user_mode_o after INIT-1 edges", int'(user_mode_o), 0);
    hold(1'b1, 8'hC9, ph);
    hold(1'b0, 8'hC9, ph);
    chk(user_mode_o == 1'b1, "R8", "user_mode_o after INIT edges", int'(user_mode_o), 1);
    chk(rx_bits.size() == nstrobe, "R7", "strobes after done", rx_bits.size(), nstrobe);
  endtask

  task automatic check_stream(input string req);
    chk(rx_bits.size() == TOT * 8, "R3", "strobe count", rx_bits.size(), TOT * 8);
    for (int b = 0; b < TOT; b++) begin
      logic [7:0] got;
      got = '0;
      for (int k = 0; k < 8; k++)
        if (b * 8 + k < rx_bits.size()) got[k] = rx_bits[b * 8 + k];
      chk(got == tx_bytes[b], req, "reassembled byte", int'(got), int'(tx_bytes[b]));
      chk(got == tx_bytes[b], "R5", "no reload mid-byte", int'(got), int'(tx_bytes[b]));
    end
  endtask

  task automatic finish_test();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_test();
  end

  initial begin
    model_clear();
    do_reset();
    // R2: toggling inside the hold-off window must not capture
    for (int i = 0; i < 10; i++) begin
      hold(1'b1, 8'h5A, 8);
      hold(1'b0, 8'h5A, 8);
    end
    chk(rx_bits.size() == 0, "R2", "strobes during hold-off", rx_bits.size(), 0);
    while (cyc < HOLD + 5) tick(1'b0, 8'h00);
    send_byte(8'hA5, 8);
    send_byte(8'h3C, 8);
    send_byte(8'h01, 8);
    send_byte(8'h80, 8);
    hold(1'b0, 8'h00, 8);
    check_stream("R4");
    post_done(8);

    // R1: reset with everything asserted, then R9: reload at minimum phase width
    do_reset();
    while (cyc < HOLD + 5) tick(1'b0, 8'h00);
    send_byte(8'h5A, 5);
    send_byte(8'hC3, 5);
    send_byte(8'hFE, 5);
    send_byte(8'h7F, 5);
    hold(1'b0, 8'h00, 5);
    check_stream("R9");
    post_done(5);
    hold(1'b0, 8'h00, 8);
    finish_test();
  end
endmodule